// File: doc/BRIEF.md
# Low-Power State Controller

This block chooses the power state a processor core drops into when it executes its idle instruction, and decides when to bring the core back. Two held control bits steer the choice. The first is a power-down enable. The second selects between the deep stop and the shallow stop. A board-level strap can forbid the low-power states entirely. Once the core leaves privileged operation, both bits are locked.

While the core sleeps, the block qualifies incoming wake requests against the current state. The external interrupt wakes from every sleep state. The timer interrupt wakes only from the shallow states. In the hard-watchdog configuration, the external interrupt wakes the core even when it is masked.

The outputs are gating enables for five clock domains (CPU, peripherals, timer, oscillator, watchdog), the current state code, and a single-cycle wake strobe to the core.

Top module: `lpm_ctrl`

## Requirements
- R1: `cur_mode` encodes RUN=0, IDLE=1, STANDBY=2, HALT=3. An `idle_req` seen in RUN at a clock edge moves the state at that edge. With `mode_pdn`=1 and `mode_sel`=0 it enters STANDBY. With both bits at 1 it enters HALT. With `mode_pdn`=0 it enters IDLE, whatever the value of `mode_sel`.
- R2: In STANDBY, the CPU and peripheral enables are 0 and the timer and oscillator enables are 1.
- R3: In HALT, all five enables are 0, the oscillator enable included.
- R4: A qualified external interrupt (`ext_irq_req` with `ext_irq_en`) wakes the core from IDLE, STANDBY and HALT. Any bit of `tmr_irq_req` wakes it from IDLE and STANDBY. `tmr_irq_req` is ignored in HALT.
- R5: While `lp_strap_dis`=1, mode-bit writes are ignored and `idle_req` enters IDLE even when both bits read 1.
- R6: While `priv_dis`=1, mode-bit writes are ignored. While `priv_dis`=0, a `cfg_wr` loads `cfg_pdn` and `cfg_sel` at that edge.
- R7: With `hard_wd_cfg`=1, `ext_irq_req` wakes from STANDBY and HALT even when `ext_irq_en`=0. In IDLE the mask still applies.
- R8: The watchdog enable is 0 in STANDBY and HALT and 1 in RUN and IDLE. In IDLE, only the CPU enable is 0.
- R9: A wake returns the state to RUN at the edge where it is sampled. `wake_pulse` is 1 for exactly that one cycle.
- R10: Reset gives RUN, both mode bits 0 and all enables 1, and it leaves any low-power state.
- R11: The mode bits are kept unchanged through every low-power state. `idle_req` is ignored outside RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| idle_req | input | 1 | Idle instruction strobe from the core |
| cfg_wr | input | 1 | Write strobe for the mode bits |
| cfg_pdn | input | 1 | Power-down enable value to write |
| cfg_sel | input | 1 | Halt (1) / standby (0) select value to write |
| priv_dis | input | 1 | Privilege disabled; locks the mode bits |
| lp_strap_dis | input | 1 | Strap forbidding low-power states |
| hard_wd_cfg | input | 1 | Hard-watchdog configuration selected |
| ext_irq_req | input | 1 | External interrupt request |
| ext_irq_en | input | 1 | External interrupt enable (mask) |
| tmr_irq_req | input | NUM_TMR_SRC | Timer interrupt requests, already qualified |
| mode_pdn | output | 1 | Held power-down enable bit |
| mode_sel | output | 1 | Held halt/standby select bit |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| osc_en | output | 1 | Oscillator enable |
| wdt_clk_en | output | 1 | Watchdog clock enable |
| cur_mode | output | 2 | Current power state code |
| wake_pulse | output | 1 | One-cycle wake strobe to the core |

## Verification
Every output comes from a register, so each result is due one rising edge after its stimulus is applied. This covers a state entry, a wake, the wake strobe and a mode-bit write alike. The driver applies inputs on the falling edge and waits for the next rising edge. It then queues the expected state, mode bits, enables and strobe. The monitor compares them at the following falling edge, half a period away from any edge that could change them. Cases where something must not happen are checked in the same cycle slot: the state stays in HALT, or the bits keep their old values.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_IDLE = 2'd1,
        PS_STBY = 2'd2,
        PS_HALT = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic pdn;   // power-down enable
        logic sel;   // 1: deep stop, 0: shallow stop
    } mode_bits_t;

    localparam int NUM_DOM    = 5;
    localparam int DOM_CPU    = 0;
    localparam int DOM_PERIPH = 1;
    localparam int DOM_TMR    = 2;
    localparam int DOM_OSC    = 3;
    localparam int DOM_WDT    = 4;

    // State entered on an idle request.
    function automatic pwr_state_e sleep_target(mode_bits_t m, logic strap_dis);
        if (strap_dis || !m.pdn) return PS_IDLE;
        else if (m.sel)          return PS_HALT;
        else                     return PS_STBY;
    endfunction

    // Whether clock domain d keeps running in state s.
    function automatic logic dom_alive(pwr_state_e s, int d);
        case (s)
            PS_RUN:  return 1'b1;
            PS_IDLE: return (d != DOM_CPU);
            PS_STBY: return (d == DOM_TMR) || (d == DOM_OSC);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_deep(pwr_state_e s);
        return (s == PS_STBY) || (s == PS_HALT);
    endfunction

endpackage

// File: rtl/lpm_mode_regs.sv
module lpm_mode_regs
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  mode_bits_t wr_val_i,
    input  logic       priv_dis_i,
    input  logic       strap_dis_i,
    output mode_bits_t mode_o
);
    logic wr_ok;

    always_comb wr_ok = wr_i && !priv_dis_i && !strap_dis_i;

    always_ff @(posedge clk) begin
        if (rst)        mode_o <= '0;
        else if (wr_ok) mode_o <= wr_val_i;
    end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
#(
    parameter int NUM_TMR_SRC = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   idle_req_i,
    input  pwr_state_e             target_i,
    input  logic                   ext_irq_i,
    input  logic                   ext_en_i,
    input  logic                   hard_wd_i,
    input  logic [NUM_TMR_SRC-1:0] tmr_irq_i,
    output pwr_state_e             state_o,
    output logic                   wake_o
);
    pwr_state_e nxt;
    logic       ext_q;
    logic       tmr_q;
    logic       wake;

    always_comb begin
        ext_q = ext_irq_i && (ext_en_i || (hard_wd_i && is_deep(state_o)));
        tmr_q = |tmr_irq_i;
        case (state_o)
            PS_IDLE, PS_STBY: wake = ext_q || tmr_q;
            PS_HALT:          wake = ext_q;
            default:          wake = 1'b0;
        endcase
        nxt = state_o;
        if (state_o == PS_RUN) begin
            if (idle_req_i) nxt = target_i;
        end else if (wake) begin
            nxt = PS_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= PS_RUN;
            wake_o  <= 1'b0;
        end else begin
            state_o <= nxt;
            wake_o  <= (state_o != PS_RUN) && wake;
        end
    end
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
    import lpm_pkg::*;
(
    input  pwr_state_e         state_i,
    output logic [NUM_DOM-1:0] en_o
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign en_o[d] = dom_alive(state_i, d);
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_TMR_SRC = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   idle_req,
    input  logic                   cfg_wr,
    input  logic                   cfg_pdn,
    input  logic                   cfg_sel,
    input  logic                   priv_dis,
    input  logic                   lp_strap_dis,
    input  logic                   hard_wd_cfg,
    input  logic                   ext_irq_req,
    input  logic                   ext_irq_en,
    input  logic [NUM_TMR_SRC-1:0] tmr_irq_req,
    output logic                   mode_pdn,
    output logic                   mode_sel,
    output logic                   cpu_clk_en,
    output logic                   periph_clk_en,
    output logic                   tmr_clk_en,
    output logic                   osc_en,
    output logic                   wdt_clk_en,
    output logic [1:0]             cur_mode,
    output logic                   wake_pulse
);
    mode_bits_t         mode;
    mode_bits_t         wr_val;
    pwr_state_e         state;
    logic [NUM_DOM-1:0] dom_en;

    assign wr_val = '{pdn: cfg_pdn, sel: cfg_sel};

    lpm_mode_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (cfg_wr),
        .wr_val_i    (wr_val),
        .priv_dis_i  (priv_dis),
        .strap_dis_i (lp_strap_dis),
        .mode_o      (mode)
    );

    lpm_fsm #(.NUM_TMR_SRC(NUM_TMR_SRC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .idle_req_i (idle_req),
        .target_i   (sleep_target(mode, lp_strap_dis)),
        .ext_irq_i  (ext_irq_req),
        .ext_en_i   (ext_irq_en),
        .hard_wd_i  (hard_wd_cfg),
        .tmr_irq_i  (tmr_irq_req),
        .state_o    (state),
        .wake_o     (wake_pulse)
    );

    lpm_clk_decode u_dec (
        .state_i (state),
        .en_o    (dom_en)
    );

    assign mode_pdn      = mode.pdn;
    assign mode_sel      = mode.sel;
    assign cur_mode      = state;
    assign cpu_clk_en    = dom_en[DOM_CPU];
    assign periph_clk_en = dom_en[DOM_PERIPH];
    assign tmr_clk_en    = dom_en[DOM_TMR];
    assign osc_en        = dom_en[DOM_OSC];
    assign wdt_clk_en    = dom_en[DOM_WDT];
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
    parameter int NUM_TMR_SRC = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_wr,
    input logic                   priv_dis,
    input logic                   lp_strap_dis,
    input logic                   ext_irq_req,
    input logic [NUM_TMR_SRC-1:0] tmr_irq_req,
    input logic                   mode_pdn,
    input logic                   mode_sel,
    input logic                   cpu_clk_en,
    input logic                   periph_clk_en,
    input logic                   tmr_clk_en,
    input logic                   osc_en,
    input logic                   wdt_clk_en,
    input logic [1:0]             cur_mode,
    input logic                   wake_pulse
);
    AST_STBY_GATING: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 2'd2 |-> !cpu_clk_en && !periph_clk_en && tmr_clk_en && osc_en); // R2
    AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 2'd3 |-> !cpu_clk_en && !periph_clk_en && !tmr_clk_en && !osc_en); // R3
    AST_HALT_TMR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd3 && !ext_irq_req) |=> cur_mode == 2'd3); // R4
    AST_STBY_TMR_WAKE: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 2'd2 && (|tmr_irq_req)) |=> cur_mode == 2'd0); // R4
    AST_STRAP_LOCK: assert property (@(posedge clk) disable iff (rst)
        (lp_strap_dis && cfg_wr) |=> $stable(mode_pdn) && $stable(mode_sel)); // R5
    AST_PRIV_LOCK: assert property (@(posedge clk) disable iff (rst)
        (priv_dis && cfg_wr) |=> $stable(mode_pdn) && $stable(mode_sel)); // R6
    AST_WDT_GATED_DEEP: assert property (@(posedge clk) disable iff (rst)
        cur_mode[1] |-> !wdt_clk_en); // R8
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse); // R9
    AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> cur_mode == 2'd0 && cpu_clk_en); // R9
    AST_BITS_KEPT_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != 2'd0 && !cfg_wr) |=> $stable(mode_pdn) && $stable(mode_sel)); // R11
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_TMR_SRC(NUM_TMR_SRC)) u_chk (.*);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
    localparam int NTS = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_req = 0, cfg_wr = 0, cfg_pdn = 0, cfg_sel = 0;
    logic priv_dis = 0, lp_strap_dis = 0, hard_wd_cfg = 0;
    logic ext_irq_req = 0, ext_irq_en = 0;
    logic [NTS-1:0] tmr_irq_req = '0;
    logic mode_pdn, mode_sel, cpu_clk_en, periph_clk_en, tmr_clk_en, osc_en, wdt_clk_en;
    logic [1:0] cur_mode;
    logic wake_pulse;

    always #2 clk = ~clk;

    lpm_ctrl #(.NUM_TMR_SRC(NTS)) dut_i (.*);

    typedef struct {
        string      tag;
        logic [1:0] mode;
        logic       pdn;
        logic       sel;
        logic       wake;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 0;

    // Enables {cpu, periph, tmr, osc, wdt} per state code, from R2, R3, R8, R10.
    function automatic logic [4:0] exp_en(logic [1:0] m);
        case (m)
            2'd0:    return 5'b11111;
            2'd1:    return 5'b01111;
            2'd2:    return 5'b00110;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: inputs are already set at a falling edge; queue the result due after the rising edge.
    task automatic tick(string tag, logic [1:0] m, logic p, logic s, logic w);
        exp_t e;
        @(posedge clk);
        #1;
        e.tag = tag; e.mode = m; e.pdn = p; e.sel = s; e.wake = w;
        exp_q.push_back(e);
        @(negedge clk);
        idle_req = 0; cfg_wr = 0; ext_irq_req = 0; tmr_irq_req = '0;
    endtask

    // Monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "cur_mode", cur_mode, e.mode);
                cmp(e.tag, "enables",
                    {cpu_clk_en, periph_clk_en, tmr_clk_en, osc_en, wdt_clk_en}, exp_en(e.mode));
                cmp(e.tag, "mode_bits", {mode_pdn, mode_sel}, {e.pdn, e.sel});
                cmp(e.tag, "wake_pulse", wake_pulse, e.wake);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick("R10 reset", 2'd0, 0, 0, 0);
        tick("R10 reset", 2'd0, 0, 0, 0);
        rst = 0;
        // plain idle with pdn=0, sel=1 ignored
        cfg_wr = 1; cfg_pdn = 0; cfg_sel = 1;   tick("R6 write", 2'd0, 0, 1, 0);
        idle_req = 1;                           tick("R1 idle", 2'd1, 0, 1, 0);
        ext_irq_req = 1; ext_irq_en = 0; hard_wd_cfg = 1;
                                                tick("R7 idle mask", 2'd1, 0, 1, 0);
        tick("R8 idle hold", 2'd1, 0, 1, 0);
        tmr_irq_req = 5'b00100;                 tick("R4 idle tmr", 2'd0, 0, 1, 1);
        tick("R9 pulse end", 2'd0, 0, 1, 0);
        hard_wd_cfg = 0;
        // standby
        cfg_wr = 1; cfg_pdn = 1; cfg_sel = 0;   tick("R6 write", 2'd0, 1, 0, 0);
        idle_req = 1;                           tick("R1 stby", 2'd2, 1, 0, 0);
        idle_req = 1;                           tick("R11 idle ignored", 2'd2, 1, 0, 0);
        tmr_irq_req = 5'b10000;                 tick("R4 stby tmr", 2'd0, 1, 0, 1);
        tick("R9 pulse end", 2'd0, 1, 0, 0);
        // halt
        cfg_wr = 1; cfg_sel = 1;                tick("R6 write", 2'd0, 1, 1, 0);
        idle_req = 1;                           tick("R1 halt", 2'd3, 1, 1, 0);
        tmr_irq_req = 5'b00001;                 tick("R4 halt tmr ignored", 2'd3, 1, 1, 0);
        ext_irq_req = 1;                        tick("R7 masked no hardwd", 2'd3, 1, 1, 0);
        hard_wd_cfg = 1; ext_irq_req = 1;       tick("R7 hardwd wake", 2'd0, 1, 1, 1);
        tick("R11 bits kept", 2'd0, 1, 1, 0);
        hard_wd_cfg = 0;
        // strap
        lp_strap_dis = 1;
        cfg_wr = 1; cfg_pdn = 0; cfg_sel = 0;   tick("R5 write ignored", 2'd0, 1, 1, 0);
        idle_req = 1;                           tick("R5 idle forced", 2'd1, 1, 1, 0);
        ext_irq_req = 1; ext_irq_en = 1;        tick("R4 idle ext", 2'd0, 1, 1, 1);
        lp_strap_dis = 0; ext_irq_en = 0;
        // privilege lock, then reset from halt
        priv_dis = 1;
        cfg_wr = 1; cfg_pdn = 0; cfg_sel = 0;   tick("R6 write ignored", 2'd0, 1, 1, 0);
        idle_req = 1;                           tick("R3 halt", 2'd3, 1, 1, 0);
        rst = 1;                                tick("R10 reset wake", 2'd0, 0, 0, 0);
        rst = 0; priv_dis = 0;
        tick("R10 after reset", 2'd0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule